// File: doc/BRIEF.md
# HDLC Transmit Bit Processor

This block turns a stream of host-supplied bytes into a bit-stuffed HDLC serial stream. The host places one byte at a time, together with a flag-request bit, into a one-entry input register through a valid/ready handshake. Once transmission is enabled, the byte moves into a shift register and goes out one bit per clock, least significant bit first. A zero is inserted after every fifth consecutive one of payload data. A bit-valid strobe marks every emitted bit, including the inserted zeros.

In parallel, a 16-bit CRC built on the polynomial x^16 + x^12 + x^5 + 1 advances on every payload bit. A flag request sends the pattern 0x7E as it is: no stuffing, no CRC update, and the run-of-ones count is cleared. Dropping the enable flushes the shifter and the run count and presets the CRC. This gives the host a clean start for each frame.

Top module: `hdlc_tx_bitproc`

## Requirements
- R1: While reset is asserted and right after it, bit_valid is 0, wr_ready is 1 and crc_out is 16'hFFFF.
- R2: A byte is accepted on a clock where wr_valid and wr_ready are both 1. wr_ready is 0 while an accepted byte waits in the input register. It returns to 1 on the cycle after that byte moves into the shift register.
- R3: While tx_en is 0 no bit is emitted (bit_valid stays 0), and a written byte waits in the input register. Conversion starts only when tx_en is 1 and a byte is waiting.
- R4: Each byte is sent least significant bit first, one bit per clock, each bit marked by bit_valid = 1. A byte already waiting follows the previous one with no idle cycle.
- R5: After five consecutive payload ones, a single 0 is emitted with bit_valid = 1. The run count carries across byte boundaries.
- R6: The inserted 0 is emitted even when no further byte is waiting after the fifth one.
- R7: A byte written with wr_flag = 1 is emitted as exactly its 8 bits, with no zero inserted, even for 0x7E (sent as 0,1,1,1,1,1,1,0). It leaves crc_out unchanged and clears the run count.
- R8: crc_out is preset to 16'hFFFF and advances once per payload bit, never on inserted zeros or flag bits. It uses the right-shifting form of x^16 + x^12 + x^5 + 1 (xor mask 16'h8408 when bit 0 of the CRC differs from the data bit). The nine ASCII bytes "123456789" yield 16'h6F91.
- R9: One clock after tx_en is 0, crc_out reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Transmit enable; low flushes the shifter and presets the CRC |
| wr_valid | input | 1 | Host offers a byte |
| wr_flag | input | 1 | Offered byte is a flag, sent without stuffing or CRC |
| wr_data | input | 8 | Offered byte |
| wr_ready | output | 1 | Input register is empty and can take a byte |
| bit_out | output | 1 | Serial output bit |
| bit_valid | output | 1 | bit_out carries a bit this cycle |
| crc_out | output | 16 | Running CRC of payload bits |

## Verification
A wrong run count shows at the serial port within six bit times: a zero goes missing or appears where none belongs, and every later bit lines up wrongly against the bench's expected stream. A CRC advanced on the wrong bits, or not preset, shows on crc_out one cycle after the offending bit. A handshake fault shows as a lost or repeated byte, or as an idle gap between bytes. The bench compares whole bit streams, bit positions and CRC values against its own model to catch each of these.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CRC_W   = 16;
  localparam int unsigned RUN_LEN = 5;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_PRESET    = 16'hFFFF;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_STUFF = 2'd1,
    SRC_DATA  = 2'd2,
    SRC_FLAG  = 2'd3
  } bit_src_e;
endpackage

// File: rtl/hdlc_tx_hold.sv
module hdlc_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic         wr_flag,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         wr_ready,
  output logic         full_o,
  output logic         flag_o,
  output logic [W-1:0] data_o
);
  logic         full_q, full_d;
  logic         flag_q, flag_d;
  logic [W-1:0] data_q, data_d;
  logic         fire;

  assign fire     = wr_valid && !full_q;
  assign wr_ready = !full_q;
  assign full_o   = full_q;
  assign flag_o   = flag_q;
  assign data_o   = data_q;

  always_comb begin
    full_d = (full_q && !take) || fire;
    flag_d = flag_q;
    data_d = data_q;
    if (fire) begin
      flag_d = wr_flag;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      flag_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      flag_q <= flag_d;
      data_q <= data_d;
    end
  end

  // R2: a waiting byte is never overwritten before the shifter takes it
  p_hold_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> ($stable(data_q) && full_q));
  // R2: the shifter only takes from a full register
  p_take_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int unsigned       CW     = 16,
  parameter logic [CW-1:0]     POLY   = 16'h8408,
  parameter logic [CW-1:0]     PRESET = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          bit_en,
  input  logic          bit_in,
  output logic [CW-1:0] crc_o
);
  logic [CW-1:0] crc_q, crc_d;
  logic          fb;

  assign fb    = crc_q[0] ^ bit_in;
  assign crc_o = crc_q;

  always_comb begin
    crc_d = crc_q;
    if (!tx_en)      crc_d = PRESET;
    else if (bit_en) crc_d = (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= PRESET;
    else        crc_q <= crc_d;
  end

  // R9: enable low presets the CRC
  p_crc_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (crc_q == PRESET));
  // R8: the CRC moves only on payload bits
  p_crc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !bit_en) |=> $stable(crc_q));
endmodule

// File: rtl/hdlc_tx_shifter.sv
module hdlc_tx_shifter
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned RUN = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic         hold_full,
  input  logic         hold_flag,
  input  logic [W-1:0] hold_data,
  output logic         take_o,
  output logic         bit_out_o,
  output logic         bit_valid_o,
  output logic         crc_en_o,
  output logic         crc_bit_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam int unsigned RUN_W = $clog2(RUN + 1);

  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             flag_q, flag_d;
  logic [RUN_W-1:0] ones_q, ones_d;
  logic             bout_q, bout_d;
  logic             bval_q, bval_d;
  bit_src_e         src;
  logic             cur_bit;

  assign cur_bit = sh_q[0];

  always_comb begin
    src = SRC_IDLE;
    if (tx_en) begin
      if (ones_q == RUN_W'(RUN))   src = SRC_STUFF;
      else if (left_q != '0)       src = flag_q ? SRC_FLAG : SRC_DATA;
    end
  end

  assign take_o = tx_en && hold_full &&
                  ((left_q == '0) ||
                   ((src == SRC_DATA || src == SRC_FLAG) && left_q == CNT_W'(1)));
  assign crc_en_o  = (src == SRC_DATA);
  assign crc_bit_o = cur_bit;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    flag_d = flag_q;
    ones_d = ones_q;
    bout_d = 1'b0;
    bval_d = 1'b0;
    if (!tx_en) begin
      left_d = '0;
      ones_d = '0;
    end else begin
      unique case (src)
        SRC_STUFF: begin
          bval_d = 1'b1;
          ones_d = '0;
        end
        SRC_DATA, SRC_FLAG: begin
          bval_d = 1'b1;
          bout_d = cur_bit;
          sh_d   = sh_q >> 1;
          left_d = left_q - CNT_W'(1);
          if (src == SRC_FLAG || !cur_bit) ones_d = '0;
          else                             ones_d = ones_q + RUN_W'(1);
        end
        default: ;
      endcase
      if (take_o) begin
        sh_d   = hold_data;
        left_d = CNT_W'(W);
        flag_d = hold_flag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      flag_q <= 1'b0;
      ones_q <= '0;
      bout_q <= 1'b0;
      bval_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      flag_q <= flag_d;
      ones_q <= ones_d;
      bout_q <= bout_d;
      bval_q <= bval_d;
    end
  end

  assign bit_out_o   = bout_q;
  assign bit_valid_o = bval_q;

  // R5: a full run of ones is followed by an emitted zero
  p_stuff_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && ones_q == RUN_W'(RUN)) |=> (bit_valid_o && !bit_out_o));
  // R5: the run count never passes the run length
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RUN_W'(RUN));
  // R3: nothing is emitted while disabled
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !bit_valid_o);
  // R7: a flag bit leaves the run count cleared
  p_flag_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_FLAG) |=> (ones_q == '0));
endmodule

// File: rtl/hdlc_tx_bitproc.sv
module hdlc_tx_bitproc
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned       W      = BYTE_W,
  parameter int unsigned       CW     = CRC_W,
  parameter int unsigned       RUN    = RUN_LEN,
  parameter logic [CW-1:0]     POLY   = CRC_POLY_REFL,
  parameter logic [CW-1:0]     PRESET = CRC_PRESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          wr_valid,
  input  logic          wr_flag,
  input  logic [W-1:0]  wr_data,
  output logic          wr_ready,
  output logic          bit_out,
  output logic          bit_valid,
  output logic [CW-1:0] crc_out
);
  logic         rst_meta_q, rst_sync_q;
  logic         take, hold_full, hold_flag;
  logic [W-1:0] hold_data;
  logic         crc_en, crc_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  hdlc_tx_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_sync_q), .wr_valid(wr_valid), .wr_flag(wr_flag),
    .wr_data(wr_data), .take(take), .wr_ready(wr_ready), .full_o(hold_full),
    .flag_o(hold_flag), .data_o(hold_data)
  );

  hdlc_tx_shifter #(.W(W), .RUN(RUN)) u_shift (
    .clk(clk), .rst_n(rst_sync_q), .tx_en(tx_en), .hold_full(hold_full),
    .hold_flag(hold_flag), .hold_data(hold_data), .take_o(take),
    .bit_out_o(bit_out), .bit_valid_o(bit_valid), .crc_en_o(crc_en),
    .crc_bit_o(crc_bit)
  );

  hdlc_tx_crc #(.CW(CW), .POLY(POLY), .PRESET(PRESET)) u_crc (
    .clk(clk), .rst_n(rst_sync_q), .tx_en(tx_en), .bit_en(crc_en),
    .bit_in(crc_bit), .crc_o(crc_out)
  );

  // R2: an accepted byte closes the input register for the next cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wr_valid && wr_ready) |=> !wr_ready);
endmodule

// File: tb/tb_hdlc_tx_bitproc.sv
`timescale 1ns/1ps
module tb_hdlc_tx_bitproc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_flag = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_ready, bit_out, bit_valid;
  logic [15:0] crc_out;

  always #4 clk = ~clk;

  hdlc_tx_bitproc dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
    .wr_flag(wr_flag), .wr_data(wr_data), .wr_ready(wr_ready),
    .bit_out(bit_out), .bit_valid(bit_valid), .crc_out(crc_out)
  );

  // {flag, byte}
  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    9'h17E, 9'h0FF, 9'h000, 9'h01F, 9'h0F8, 9'h07E,
    9'h0A5, 9'h03E, 9'h17E, 9'h0E0, 9'h003, 9'h0BF
  };

  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic cap     [1024];
  int   cap_cyc [1024];
  int   cap_n = 0;
  logic exp_b   [1024];
  int   exp_n = 0;
  int   m_ones = 0;
  logic [15:0] m_crc = 16'hFFFF;
  int   base = 0;
  bit   done = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bit_valid && cap_n < 1024) begin
      cap[cap_n]     <= bit_out;
      cap_cyc[cap_n] <= cyc;
      cap_n          <= cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_start();
    @(negedge clk);
    base   = cap_n;
    exp_n  = 0;
    m_ones = 0;
    m_crc  = 16'hFFFF;
  endtask

  task automatic model_push(input logic is_flag, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      exp_b[exp_n] = d[i];
      exp_n++;
      if (is_flag) m_ones = 0;
      else begin
        m_crc = (m_crc >> 1) ^ (((m_crc[0] ^ d[i]) != 1'b0) ? 16'h8408 : 16'h0000);
        if (d[i]) m_ones++; else m_ones = 0;
        if (m_ones == 5) begin
          exp_b[exp_n] = 1'b0;
          exp_n++;
          m_ones = 0;
        end
      end
    end
  endtask

  task automatic send(input logic is_flag, input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_flag  = is_flag;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    model_push(is_flag, d);
  endtask

  task automatic restart();
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    tx_en = 1'b1;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  function automatic int mismatch_at();
    for (int i = 0; i < exp_n; i++)
      if (cap[base + i] !== exp_b[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R1 bit_valid", bit_valid, 0);
    check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    check(crc_out == 16'hFFFF, "R1 crc_out", crc_out, 16'hFFFF);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 and R2: byte waits while disabled
    model_start();
    send(1'b0, 8'h55);
    begin
      int bits_seen = 0;
      int ready_seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (bit_valid) bits_seen++;
        if (wr_ready) ready_seen++;
      end
      check(bits_seen == 0, "R3 no bits while disabled", bits_seen, 0);
      check(ready_seen == 0, "R2 ready low while byte waits", ready_seen, 0);
    end
    tx_en = 1'b1;
    settle();
    check(cap_n - base == 8 && mismatch_at() < 0, "R4 R3 byte 0x55 lsb first",
          cap_n - base, 8);

    // R9: enable low presets the CRC
    check(crc_out != 16'hFFFF, "R9 crc moved before drop", crc_out, 0);
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check(crc_out == 16'hFFFF, "R9 crc preset on disable", crc_out, 16'hFFFF);
    tx_en = 1'b1;

    // R7: flag byte unstuffed, CRC untouched
    model_start();
    send(1'b1, 8'h7E);
    settle();
    check(cap_n - base == 8 && mismatch_at() < 0, "R7 flag bits", cap_n - base, 8);
    check(crc_out == 16'hFFFF, "R7 flag leaves crc", crc_out, 16'hFFFF);

    // R6: trailing stuff zero with nothing waiting
    restart();
    model_start();
    send(1'b0, 8'hF8);
    settle();
    check(cap_n - base == 9, "R6 bit count", cap_n - base, 9);
    check(cap[base + 8] == 1'b0, "R6 trailing zero", cap[base + 8], 0);

    // R5: run carries across a byte boundary
    restart();
    model_start();
    send(1'b0, 8'hE0);
    send(1'b0, 8'h03);
    settle();
    check(cap_n - base == 17, "R5 bit count", cap_n - base, 17);
    check(cap[base + 10] == 1'b0 && cap[base + 11] == 1'b0 && cap[base + 9] == 1'b1,
          "R5 stuffed position", cap[base + 10], 0);

    // R8: known CRC of "123456789"
    restart();
    model_start();
    for (int i = 0; i < 9; i++) send(1'b0, 8'h31 + 8'(i));
    settle();
    check(crc_out == 16'h6F91, "R8 crc check value", crc_out, 16'h6F91);

    // Table walk: R4 R5 R7 R8 over mixed bytes and flags
    restart();
    model_start();
    for (int v = 0; v < NV; v++) send(VEC[v][8], VEC[v][7:0]);
    settle();
    check(cap_n - base == exp_n, "R5 table stream length", cap_n - base, exp_n);
    check(mismatch_at() < 0, "R5 table first mismatch", mismatch_at(), -1);
    check(crc_out == m_crc, "R8 table crc", crc_out, m_crc);
    check(cap_cyc[cap_n - 1] - cap_cyc[base] + 1 == exp_n, "R4 no idle gap",
          cap_cyc[cap_n - 1] - cap_cyc[base] + 1, exp_n);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule